// File: doc/BRIEF.md
# Framed Payload Receiver with Host Readout

This block takes a recovered serial bit stream, which arrives as one data bit per strobe, and looks for frames in it. A frame has four parts in order: an alternating preamble, a configured address, a payload of configured length, and a check field. The block accepts a frame only when the address matches and the check field is correct. It then throws away everything except the payload and raises a ready flag.

The host reads the payload at its own pace. It toggles a clock pin, and each rising edge moves the data pin on to the next bit. The ready flag falls on the edge that consumes the last bit. A settling delay follows every rise of the enable input, and no frame is searched for during that delay. While a payload waits to be read, further frames are discarded, so held data is never overwritten.

Top module: `framed_payload_rx`

## Requirements
- R1: After reset, `data_rdy` and `host_dat` are both 0.
- R2: For `SETTLE_CYC` clock cycles after `rx_en` rises, strobed bits are ignored. A frame that arrives during this interval is not accepted.
- R3: Frame search compares the last `cfg_addr_w + 8` strobed bits with a preamble followed by the address `cfg_addr[cfg_addr_w-1:0]`, sent MSB first. The width is 8 to 40. The preamble is 8 alternating bits whose first bit equals the address MSB: 10101010 when that MSB is 1, and 01010101 when it is 0.
- R4: When `cfg_crc16` is 1, the check field is 16 bits, using polynomial 0x1021 with initial value 0xFFFF. When `cfg_crc16` is 0, it is 8 bits, using polynomial 0x07 with initial value 0xFF. In both modes the check is computed MSB first over the address and then the payload, with no final inversion, and the check field is sent MSB first. A frame whose check field does not match never raises `data_rdy`.
- R5: A frame with a matching address and a correct check field raises `data_rdy`. The payload length is `cfg_pay_len` bits, from 1 to 256.
- R6: While `data_rdy` is 1, `host_dat` shows payload bits in the order they were received, starting with the first. Each rising edge of `host_clk` advances to the next bit.
- R7: `data_rdy` stays high until the rising edge of `host_clk` that consumes the last payload bit, and then falls.
- R8: `host_dat` is 0 whenever `data_rdy` is 0.
- R9: A frame that arrives while a payload is held is dropped. The held payload is then read out unchanged.
- R10: Dropping `rx_en` while a payload is held still allows a complete readout. Raising `rx_en` again starts a new settling interval.
- R11: If `rx_en` stays high through a readout, the block searches for the next frame as soon as `data_rdy` falls, with no settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_en | input | 1 | Reception enable |
| rx_bit | input | 1 | Recovered serial bit |
| rx_stb | input | 1 | One-cycle strobe marking `rx_bit` as valid |
| cfg_addr | input | MAX_AW | Expected address, low-aligned |
| cfg_addr_w | input | AW_W | Address width in bits (8 to 40) |
| cfg_pay_len | input | PL_W | Payload length in bits (1 to 256) |
| cfg_crc16 | input | 1 | 1 selects the 16-bit check, 0 the 8-bit check |
| host_clk | input | 1 | Host readout clock, sampled by the block clock |
| host_dat | output | 1 | Current payload bit |
| data_rdy | output | 1 | Accepted payload waiting for readout |

## Verification
The bench builds the block with the full 40-bit address and 256-bit payload limits. This allows it to reach the widest address window, a single-bit payload and a full 256-bit payload. The settling interval is shortened to 100 cycles, which lets a frame sent straight after enable fall inside it while later frames arrive well after it. Table cases cover both preamble polarities, both check widths, a corrupted check field and a wrong address. Directed cases then cover a frame arriving while a payload is held and readout with enable dropped.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam int PRE_W = 8;

  typedef enum logic [2:0] {
    ST_OFF, ST_SETTLE, ST_HUNT, ST_PAY, ST_CRC, ST_HOLD
  } rx_state_e;

  // One serial step of the check register; narrow mode lives in bits 7:0.
  function automatic logic [15:0] crc_step(logic [15:0] c, logic b, logic wide);
    logic fb;
    if (wide) begin
      fb = c[15] ^ b;
      crc_step = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end else begin
      fb = c[7] ^ b;
      crc_step = {8'h00, c[6:0], 1'b0} ^ (fb ? 16'h0007 : 16'h0000);
    end
  endfunction

  function automatic logic [15:0] crc_seed(logic wide);
    crc_seed = wide ? 16'hFFFF : 16'h00FF;
  endfunction
endpackage

// File: rtl/frx_settle.sv
module frx_settle #(
  parameter int SETTLE_CYC = 50000,
  localparam int CW = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == CW'(SETTLE_CYC - 1));

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  settle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);
endmodule

// File: rtl/frx_addr_match.sv
module frx_addr_match
  import frx_pkg::*;
#(
  parameter int MAX_AW = 40,
  localparam int AW_W = $clog2(MAX_AW + 1),
  localparam int WIN = MAX_AW + PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic              bit_in,
  input  logic [MAX_AW-1:0] cfg_addr,
  input  logic [AW_W-1:0]   cfg_aw,
  input  logic              wide,
  output logic              hit,
  output logic [15:0]       seed
);
  logic [WIN-1:0]   win_q, win_d, win_nxt, exp_v, mask_v, amask;
  logic [PRE_W-1:0] pre_v;
  logic             amsb;

  always_comb begin
    win_nxt = {win_q[WIN-2:0], bit_in};
    amsb = 1'b0;
    for (int i = 0; i < MAX_AW; i++)
      if (i + 1 == int'(cfg_aw)) amsb = cfg_addr[i];
    for (int i = 0; i < PRE_W; i++)
      pre_v[i] = (i % 2 == 1) ? amsb : ~amsb;
    for (int i = 0; i < WIN; i++) begin
      amask[i]  = (i < int'(cfg_aw));
      mask_v[i] = (i < int'(cfg_aw) + PRE_W);
    end
    exp_v = ({{MAX_AW{1'b0}}, pre_v} << cfg_aw) | ({{PRE_W{1'b0}}, cfg_addr} & amask);
    hit   = (((win_nxt ^ exp_v) & mask_v) == '0);
  end

  // Check register preloaded with the address contribution.
  always_comb begin
    seed = crc_seed(wide);
    for (int i = MAX_AW - 1; i >= 0; i--)
      if (i < int'(cfg_aw)) seed = crc_step(seed, cfg_addr[i], wide);
  end

  always_comb begin
    if (clr)        win_d = '0;
    else if (shift) win_d = win_nxt;
    else            win_d = win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  // R3
  win_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift && !clr |=> $stable(win_q));
endmodule

// File: rtl/frx_readout.sv
module frx_readout #(
  parameter int MAX_PW = 256,
  localparam int PL_W = $clog2(MAX_PW + 1),
  localparam int IDX_W = $clog2(MAX_PW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap,
  input  logic            cap_bit,
  input  logic            load,
  input  logic [PL_W-1:0] cfg_len,
  input  logic            host_clk,
  output logic            host_dat,
  output logic            data_rdy
);
  logic [MAX_PW-1:0] buf_q, buf_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              rdy_q, rdy_d;
  logic [2:0]        hs_q, hs_d;
  logic              hrise;

  assign hrise    = hs_q[1] & ~hs_q[2];
  assign hs_d     = {hs_q[1:0], host_clk};
  assign data_rdy = rdy_q;
  assign host_dat = rdy_q & buf_q[idx_q];

  always_comb begin
    buf_d = buf_q;
    idx_d = idx_q;
    rdy_d = rdy_q;
    if (cap) buf_d = {buf_q[MAX_PW-2:0], cap_bit};
    if (load) begin
      rdy_d = 1'b1;
      idx_d = IDX_W'(cfg_len - 1'b1);
    end else if (rdy_q && hrise) begin
      if (idx_q == '0) rdy_d = 1'b0;
      else             idx_d = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      idx_q <= '0;
      rdy_q <= 1'b0;
      hs_q  <= '0;
    end else begin
      buf_q <= buf_d;
      idx_q <= idx_d;
      rdy_q <= rdy_d;
      hs_q  <= hs_d;
    end
  end

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> !cap);
  // R7
  last_edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_q) |-> $past(hrise) && $past(idx_q) == '0);
  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q && !hrise |=> $stable(idx_q));
endmodule

// File: rtl/framed_payload_rx.sv
module framed_payload_rx
  import frx_pkg::*;
#(
  parameter int MAX_AW = 40,
  parameter int MAX_PW = 256,
  parameter int SETTLE_CYC = 50000,
  localparam int AW_W = $clog2(MAX_AW + 1),
  localparam int PL_W = $clog2(MAX_PW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_bit,
  input  logic              rx_stb,
  input  logic [MAX_AW-1:0] cfg_addr,
  input  logic [AW_W-1:0]   cfg_addr_w,
  input  logic [PL_W-1:0]   cfg_pay_len,
  input  logic              cfg_crc16,
  input  logic              host_clk,
  output logic              host_dat,
  output logic              data_rdy
);
  logic [1:0]      rs_q;
  logic            rst_s;
  rx_state_e       st_q, st_d;
  logic [PL_W-1:0] cnt_q, cnt_d;
  logic [15:0]     crc_q, crc_d, crc_nxt, seed;
  logic            drop_q, drop_d;
  logic            settle_run, settle_done, win_clr, win_shift, hit, cap, accept;
  logic [PL_W-1:0] crc_last;

  // Reset asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  frx_settle #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk(clk), .rst_n(rst_s), .run(settle_run), .done(settle_done)
  );

  frx_addr_match #(.MAX_AW(MAX_AW)) i_match (
    .clk(clk), .rst_n(rst_s), .clr(win_clr), .shift(win_shift), .bit_in(rx_bit),
    .cfg_addr(cfg_addr), .cfg_aw(cfg_addr_w), .wide(cfg_crc16), .hit(hit), .seed(seed)
  );

  frx_readout #(.MAX_PW(MAX_PW)) i_read (
    .clk(clk), .rst_n(rst_s), .cap(cap), .cap_bit(rx_bit), .load(accept),
    .cfg_len(cfg_pay_len), .host_clk(host_clk), .host_dat(host_dat), .data_rdy(data_rdy)
  );

  assign crc_last = cfg_crc16 ? PL_W'(15) : PL_W'(7);
  assign crc_nxt  = crc_step(crc_q, rx_bit, cfg_crc16);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    crc_d      = crc_q;
    drop_d     = drop_q;
    settle_run = (st_q == ST_SETTLE);
    win_clr    = 1'b0;
    win_shift  = 1'b0;
    cap        = 1'b0;
    accept     = 1'b0;
    case (st_q)
      ST_OFF: if (rx_en) st_d = ST_SETTLE;
      ST_SETTLE: begin
        if (!rx_en) st_d = ST_OFF;
        else if (settle_done) begin
          st_d    = ST_HUNT;
          win_clr = 1'b1;
        end
      end
      ST_HUNT: begin
        if (!rx_en) st_d = ST_OFF;
        else if (rx_stb) begin
          win_shift = 1'b1;
          if (hit) begin
            st_d  = ST_PAY;
            cnt_d = '0;
            crc_d = seed;
          end
        end
      end
      ST_PAY: begin
        if (!rx_en) st_d = ST_OFF;
        else if (rx_stb) begin
          cap   = 1'b1;
          crc_d = crc_nxt;
          if (cnt_q == cfg_pay_len - 1'b1) begin
            st_d  = ST_CRC;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_CRC: begin
        if (!rx_en) st_d = ST_OFF;
        else if (rx_stb) begin
          crc_d = crc_nxt;
          if (cnt_q == crc_last) begin
            if (crc_nxt == 16'h0000) begin
              accept = 1'b1;
              drop_d = 1'b0;
              st_d   = ST_HOLD;
            end else begin
              st_d    = ST_HUNT;
              win_clr = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (!rx_en) drop_d = 1'b1;
        if (!data_rdy) begin
          drop_d = 1'b0;
          if (rx_en && !drop_q) begin
            st_d    = ST_HUNT;
            win_clr = 1'b1;
          end else begin
            st_d = ST_OFF;
          end
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_OFF;
      cnt_q  <= '0;
      crc_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      crc_q  <= crc_d;
      drop_q <= drop_d;
    end
  end

  // R2
  settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    st_q == ST_HUNT && $past(st_q) != ST_HUNT |->
      $past(st_q) inside {ST_SETTLE, ST_CRC, ST_HOLD});
  // R5
  rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(data_rdy) |-> $past(st_q) == ST_CRC);
  // R10
  off_to_settle_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $past(st_q) == ST_OFF |-> st_q inside {ST_OFF, ST_SETTLE});
  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !data_rdy |-> !host_dat);
endmodule

// File: tb/test_framed_payload_rx.sv
`timescale 1ns/1ps
module test_framed_payload_rx;
  localparam int MAX_AW = 40;
  localparam int MAX_PW = 256;
  localparam int SETTLE = 100;
  localparam int NCASE = 6;

  // address cfg, address sent, width, length, 16-bit check, pattern, corrupt, accept
  localparam logic [39:0] T_CA [NCASE] = '{40'h00000000A5, 40'h123456789A, 40'h0000003C5A,
                                          40'h0000817E42, 40'h00000055AA, 40'h00000000C3};
  localparam logic [39:0] T_SA [NCASE] = '{40'h00000000A5, 40'h123456789A, 40'h0000003C5A,
                                          40'h0000817E42, 40'h00000055AA, 40'h00000000C7};
  localparam int T_AW  [NCASE] = '{8, 40, 16, 24, 16, 8};
  localparam int T_LEN [NCASE] = '{8, 32, 256, 1, 16, 12};
  localparam bit T_W   [NCASE] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [63:0] T_PAT [NCASE] = '{64'h0123456789ABCDEF, 64'hF0E1D2C3B4A59687,
                                           64'hDEADBEEF0BADF00D, 64'h1, 64'hCAFE, 64'h777};
  localparam bit T_BAD [NCASE] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam bit T_ACC [NCASE] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n, rx_en, rx_bit, rx_stb, cfg_crc16, host_clk;
  logic [39:0] cfg_addr;
  logic [5:0]  cfg_addr_w;
  logic [8:0]  cfg_pay_len;
  logic        host_dat, data_rdy;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  framed_payload_rx #(.MAX_AW(MAX_AW), .MAX_PW(MAX_PW), .SETTLE_CYC(SETTLE)) i_framed_payload_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit), .rx_stb(rx_stb),
    .cfg_addr(cfg_addr), .cfg_addr_w(cfg_addr_w), .cfg_pay_len(cfg_pay_len),
    .cfg_crc16(cfg_crc16), .host_clk(host_clk), .host_dat(host_dat), .data_rdy(data_rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic b, bit w);
    logic [15:0] r;
    if (w) r = c[15] != b ? ((c << 1) ^ 16'h1021) : (c << 1);
    else   r = {8'h00, (c[7] != b) ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0}};
    return r;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    rx_stb = 1'b1;
    @(negedge clk);
    rx_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [39:0] a, input int aw, input int len,
                            input bit w, input logic [63:0] pat, input bit bad);
    logic [15:0] c;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    for (int k = 0; k < 8; k++) send_bit(a[aw-1] ^ k[0]);
    c = w ? 16'hFFFF : 16'h00FF;
    for (int i = aw - 1; i >= 0; i--) begin
      c = ref_crc(c, a[i], w);
      send_bit(a[i]);
    end
    for (int j = 0; j < len; j++) begin
      c = ref_crc(c, pat[j % 64], w);
      send_bit(pat[j % 64]);
    end
    if (bad) c[0] = ~c[0];
    for (int k = (w ? 15 : 7); k >= 0; k--) send_bit(c[k]);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_payload(input int len, input logic [63:0] pat);
    for (int j = 0; j < len; j++) begin
      // R6: bit j in arrival order
      chk(host_dat === pat[j % 64], "R6 payload bit", int'(host_dat), int'(pat[j % 64]));
      if (j == len - 1) chk(data_rdy === 1'b1, "R7 high before last edge", int'(data_rdy), 1);
      host_clk = 1'b1;
      repeat (4) @(negedge clk);
      host_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk(data_rdy === 1'b0, "R7 low after last bit", int'(data_rdy), 0);
    chk(host_dat === 1'b0, "R8 data low when idle", int'(host_dat), 0);
  endtask

  task automatic set_cfg(input int t);
    cfg_addr    = T_CA[t];
    cfg_addr_w  = 6'(T_AW[t]);
    cfg_pay_len = 9'(T_LEN[t]);
    cfg_crc16   = T_W[t];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; rx_bit = 1'b0; rx_stb = 1'b0; host_clk = 1'b0;
    set_cfg(0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(data_rdy === 1'b0, "R1 ready after reset", int'(data_rdy), 0);
    chk(host_dat === 1'b0, "R1 data after reset", int'(host_dat), 0);

    // R2: frame sent right after enable lands in the settling interval
    rx_en = 1'b1;
    send_frame(T_SA[0], T_AW[0], T_LEN[0], T_W[0], T_PAT[0], 1'b0);
    chk(data_rdy === 1'b0, "R2 frame during settle", int'(data_rdy), 0);
    chk(host_dat === 1'b0, "R8 data low while not ready", int'(host_dat), 0);

    // Table walk, enable held high throughout (R11 between accepted cases)
    for (int t = 0; t < NCASE; t++) begin
      set_cfg(t);
      repeat (4) @(negedge clk);
      send_frame(T_SA[t], T_AW[t], T_LEN[t], T_W[t], T_PAT[t], T_BAD[t]);
      if (t == 4)      chk(data_rdy === T_ACC[t], "R4 bad check field", int'(data_rdy), int'(T_ACC[t]));
      else if (t == 5) chk(data_rdy === T_ACC[t], "R3 wrong address", int'(data_rdy), int'(T_ACC[t]));
      else if (t == 1) chk(data_rdy === T_ACC[t], "R11 next frame without settle", int'(data_rdy), 1);
      else             chk(data_rdy === T_ACC[t], "R5 accepted frame", int'(data_rdy), int'(T_ACC[t]));
      if (T_ACC[t]) read_payload(T_LEN[t], T_PAT[t]);
    end

    // R9: second frame while holding is dropped
    set_cfg(0);
    send_frame(T_SA[0], 8, 8, 1'b1, 64'h5C, 1'b0);
    chk(data_rdy === 1'b1, "R5 first frame held", int'(data_rdy), 1);
    send_frame(T_SA[0], 8, 8, 1'b1, 64'hA3, 1'b0);
    read_payload(8, 64'h5C);
    chk(n_bad == 0, "R9 held payload intact", n_bad, 0);

    // R10: enable dropped while holding, readout still completes
    send_frame(T_SA[0], 8, 8, 1'b1, 64'h96, 1'b0);
    rx_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(data_rdy === 1'b1, "R10 held with enable low", int'(data_rdy), 1);
    read_payload(8, 64'h96);
    rx_en = 1'b1;
    send_frame(T_SA[0], 8, 8, 1'b1, 64'h3B, 1'b0);
    chk(data_rdy === 1'b0, "R10 new settle after re-enable", int'(data_rdy), 0);
    send_frame(T_SA[0], 8, 8, 1'b1, 64'h3B, 1'b0);
    chk(data_rdy === 1'b1, "R10 accepted after settle", int'(data_rdy), 1);
    read_payload(8, 64'h3B);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule